// File: doc/BRIEF.md
# Power-On Self-Test Reset Sequencer

This block controls how a processor core leaves reset. It watches an active-low system reset input. Once that input is released, it counts system clock cycles and walks through a built-in self-test phase, which is modelled here as a cycle counter. The phase is reported on a two-bit status output. The block also drives an internal active-low core reset, and decides when that reset may be released.

Without a boot ROM, the core reset is released at a programmable point shortly before the self-test window closes. With a boot ROM, a strap marks the ROM as present, and the end of self-test then fires a one-cycle start pulse to an external ROM loader. The core reset stays asserted until the loader reports that it has finished.

All three timing points are parameters, each counted in system cycles from the release of system reset: the test start, the reset-release point and the test end. A testbench can therefore shorten them, and a design can fit them to any clock ratio. Pulling system reset low at any time aborts the sequence.

Top module: `post_rst_seq`

## Requirements
- R1: At every rising edge where `sys_rst_n` is sampled low, the outputs after that edge are `test_status` = 2'b11 (idle), `core_rst_n` = 0 and `rom_load_start` = 0.
- R2: Count rising edges from the first one where `sys_rst_n` is sampled high as k = 1, 2, and so on. `test_status` reads 2'b11 after edges k < START_CYC, 2'b01 (testing) after edges START_CYC ≤ k < DONE_CYC, and 2'b00 (complete) from edge DONE_CYC onward. The code 2'b10 never appears.
- R3: With the strap latched inactive, `core_rst_n` rises after edge REL_CYC, where START_CYC < REL_CYC < DONE_CYC. `rom_load_start` never pulses.
- R4: With the strap latched active, `rom_load_start` is high for exactly the one cycle after edge DONE_CYC, and only once per sequence.
- R5: With the strap latched active, `core_rst_n` stays 0 until the first edge after edge DONE_CYC at which `rom_load_done` is sampled high. It rises after that edge. `rom_load_done` at or before edge DONE_CYC has no effect.
- R6: `rom_strap` is sampled only at edge k = 1. Later changes to it do not alter the sequence.
- R7: Pulling `sys_rst_n` low mid-sequence returns the outputs to the R1 state after the next edge. A later release restarts the count from k = 1.
- R8: Once `core_rst_n` has risen, it stays high until `sys_rst_n` is next sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Active-low system reset, sampled synchronously |
| rom_strap | input | 1 | High when a boot ROM is fitted; latched at edge k = 1 |
| rom_load_done | input | 1 | Level from the ROM loader, high once the load has finished |
| rom_load_start | output | 1 | One-cycle pulse that starts the ROM load |
| test_status | output | 2 | 11 idle, 01 self-test running, 00 self-test complete |
| core_rst_n | output | 1 | Active-low internal reset for the core |

## Verification
The checks assume that `sys_rst_n` is synchronous to `clk`, that it is low at the first edge, and that the parameters satisfy 1 ≤ START_CYC < REL_CYC < DONE_CYC. The stimulus changes every input one nanosecond after a rising edge, so each input is stable for the whole period before the next sampling edge. The stimulus also keeps `rom_load_done` as a level that the loader raises at some point after the start pulse. Before that point it toggles freely, and the bench expects those toggles to be ignored.

// File: rtl/posr_pkg.sv
`timescale 1ns/1ps
package posr_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_TEST, PH_DONE} phase_e;
  typedef enum logic [1:0] {HS_OFF, HS_WAIT, HS_FIN} hs_e;

  localparam logic [1:0] STAT_IDLE = 2'b11;
  localparam logic [1:0] STAT_RUN  = 2'b01;
  localparam logic [1:0] STAT_END  = 2'b00;

  function automatic logic [1:0] status_code(input phase_e ph);
    case (ph)
      PH_TEST: status_code = STAT_RUN;
      PH_DONE: status_code = STAT_END;
      default: status_code = STAT_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/posr_timer.sv
`timescale 1ns/1ps
// Saturating count of edges since system reset release.
module posr_timer #(
  parameter int unsigned LIMIT = 16,
  parameter int unsigned CW    = 5
) (
  input  logic          clk,
  input  logic          run,
  output logic [CW-1:0] cnt_nxt,
  output logic          first,
  output logic          reach
);
  localparam logic [CW-1:0] LIM_V  = CW'(LIMIT);
  localparam logic [CW-1:0] PRE_V  = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_comb begin
    if (!run)              cnt_nxt = '0;
    else if (cnt == LIM_V) cnt_nxt = cnt;
    else                   cnt_nxt = cnt + 1'b1;
  end

  always_ff @(posedge clk) cnt <= cnt_nxt;

  assign first = run && (cnt == '0);
  assign reach = run && (cnt == PRE_V);
endmodule

// File: rtl/posr_phase_dec.sv
`timescale 1ns/1ps
// Maps the upcoming count onto the sequence phase and the release point.
module posr_phase_dec
  import posr_pkg::*;
#(
  parameter int unsigned START_CYC = 4,
  parameter int unsigned REL_CYC   = 15,
  parameter int unsigned DONE_CYC  = 16,
  parameter int unsigned CW        = 5
) (
  input  logic          run,
  input  logic [CW-1:0] cnt_nxt,
  output phase_e        phase,
  output logic          rel_hit
);
  localparam logic [CW-1:0] START_V = CW'(START_CYC);
  localparam logic [CW-1:0] REL_V   = CW'(REL_CYC);
  localparam logic [CW-1:0] DONE_V  = CW'(DONE_CYC);

  always_comb begin
    if (!run || cnt_nxt < START_V) phase = PH_IDLE;
    else if (cnt_nxt < DONE_V)     phase = PH_TEST;
    else                           phase = PH_DONE;
  end

  assign rel_hit = run && (cnt_nxt >= REL_V);
endmodule

// File: rtl/posr_rom_hs.sv
`timescale 1ns/1ps
// Strap latch and ROM loader handshake.
module posr_rom_hs
  import posr_pkg::*;
(
  input  logic clk,
  input  logic run,
  input  logic first,
  input  logic strap_in,
  input  logic reach,
  input  logic load_done,
  output logic strap_q,
  output logic start_q,
  output logic grant
);
  hs_e st;

  always_ff @(posedge clk) begin
    if (!run) begin
      st      <= HS_OFF;
      start_q <= 1'b0;
      strap_q <= 1'b0;
    end else begin
      if (first) strap_q <= strap_in;
      start_q <= 1'b0;
      case (st)
        HS_OFF: if (reach && strap_q) begin
          st      <= HS_WAIT;
          start_q <= 1'b1;
        end
        HS_WAIT: if (load_done) st <= HS_FIN;
        default: ;
      endcase
    end
  end

  // Release condition for the ROM path, valid for the next register update.
  assign grant = (st == HS_FIN) || (st == HS_WAIT && load_done);
endmodule

// File: rtl/post_rst_seq.sv
`timescale 1ns/1ps
module post_rst_seq
  import posr_pkg::*;
#(
  parameter int unsigned START_CYC = 7,
  parameter int unsigned REL_CYC   = 19721,
  parameter int unsigned DONE_CYC  = 19722
) (
  input  logic       clk,
  input  logic       sys_rst_n,
  input  logic       rom_strap,
  input  logic       rom_load_done,
  output logic       rom_load_start,
  output logic [1:0] test_status,
  output logic       core_rst_n
);
  localparam int unsigned CW = $clog2(DONE_CYC + 1);

  logic [CW-1:0] cnt_nxt;
  logic          first, reach, rel_hit, strap_q, grant;
  phase_e        phase;

  posr_timer #(.LIMIT(DONE_CYC), .CW(CW)) u_timer (
    .clk(clk), .run(sys_rst_n), .cnt_nxt(cnt_nxt), .first(first), .reach(reach)
  );

  posr_phase_dec #(
    .START_CYC(START_CYC), .REL_CYC(REL_CYC), .DONE_CYC(DONE_CYC), .CW(CW)
  ) u_dec (
    .run(sys_rst_n), .cnt_nxt(cnt_nxt), .phase(phase), .rel_hit(rel_hit)
  );

  posr_rom_hs u_hs (
    .clk(clk), .run(sys_rst_n), .first(first), .strap_in(rom_strap),
    .reach(reach), .load_done(rom_load_done), .strap_q(strap_q),
    .start_q(rom_load_start), .grant(grant)
  );

  always_ff @(posedge clk) begin
    if (!sys_rst_n) begin
      test_status <= STAT_IDLE;
      core_rst_n  <= 1'b0;
    end else begin
      test_status <= status_code(phase);
      core_rst_n  <= strap_q ? grant : rel_hit;
    end
  end
endmodule

// File: rtl/post_rst_seq_chk.sv
`timescale 1ns/1ps
module post_rst_seq_chk (
  input logic       clk,
  input logic       sys_rst_n,
  input logic       rom_load_start,
  input logic [1:0] test_status,
  input logic       core_rst_n
);
  assert_idle_R1: assert property (@(posedge clk)
    !sys_rst_n |=> (test_status == 2'b11 && !core_rst_n && !rom_load_start));

  assert_code_R2: assert property (@(posedge clk) disable iff (!sys_rst_n)
    test_status != 2'b10);

  assert_done_hold_R2: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (test_status == 2'b00) |=> (test_status == 2'b00));

  assert_no_rerun_R2: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (test_status == 2'b01) |-> ($past(test_status) != 2'b00));

  assert_pulse_R4: assert property (@(posedge clk) disable iff (!sys_rst_n)
    rom_load_start |=> !rom_load_start);

  assert_start_at_end_R4: assert property (@(posedge clk) disable iff (!sys_rst_n)
    rom_load_start |-> (test_status == 2'b00));

  assert_release_after_start_R5: assert property (@(posedge clk) disable iff (!sys_rst_n)
    $rose(core_rst_n) |-> !rom_load_start);

  assert_core_hold_R8: assert property (@(posedge clk) disable iff (!sys_rst_n)
    core_rst_n |=> core_rst_n);
endmodule

bind post_rst_seq post_rst_seq_chk u_chk (
  .clk(clk), .sys_rst_n(sys_rst_n), .rom_load_start(rom_load_start),
  .test_status(test_status), .core_rst_n(core_rst_n)
);

// File: tb/tb_post_rst_seq.sv
`timescale 1ns/1ps
module tb_post_rst_seq;
  localparam int T_START = 4;
  localparam int T_REL   = 15;
  localparam int T_DONE  = 18;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       sys_rst_n = 1'b0;
  logic       rom_strap = 1'b0;
  logic       rom_load_done = 1'b0;
  logic       rom_load_start;
  logic [1:0] test_status;
  logic       core_rst_n;

  int checks = 0;
  int fails  = 0;

  post_rst_seq #(.START_CYC(T_START), .REL_CYC(T_REL), .DONE_CYC(T_DONE)) dut (
    .clk(clk), .sys_rst_n(sys_rst_n), .rom_strap(rom_strap),
    .rom_load_done(rom_load_done), .rom_load_start(rom_load_start),
    .test_status(test_status), .core_rst_n(core_rst_n)
  );

  function automatic int exp_status(input int k);
    if (k < T_START)     return 3;
    else if (k < T_DONE) return 1;
    else                 return 0;
  endfunction

  function automatic int exp_core(input int k, input bit strap, input int d);
    if (strap) return (k >= T_DONE + d) ? 1 : 0;
    else       return (k >= T_REL) ? 1 : 0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check_idle(input string req);
    chk({req, " status"}, int'(test_status), 3);
    chk({req, " core_rst_n"}, int'(core_rst_n), 0);
    chk({req, " start"}, int'(rom_load_start), 0);
  endtask

  task automatic hold_reset(input int n);
    sys_rst_n = 1'b0;
    for (int i = 0; i < n; i++) begin
      rom_load_done = 1'($urandom_range(0, 1));
      tick();
      check_idle("R1");
    end
  endtask

  // strap: strap at release; d: edges after DONE until loader done; abort_at: 0 = none
  task automatic run_seq(input bit strap, input int d, input int abort_at);
    int last;
    hold_reset(2);
    sys_rst_n     = 1'b1;
    rom_strap     = strap;
    rom_load_done = 1'($urandom_range(0, 1));
    last = strap ? T_DONE + d + 3 : T_DONE + 3;
    for (int k = 1; k <= last; k++) begin
      tick();
      chk("R2 status", int'(test_status), exp_status(k));
      chk(strap ? "R5 core_rst_n" : "R3 core_rst_n", int'(core_rst_n), exp_core(k, strap, d));
      chk(strap ? "R4 start" : "R3 start", int'(rom_load_start), (strap && k == T_DONE) ? 1 : 0);
      if (k == 1) rom_strap = 1'($urandom_range(0, 1));  // R6: late strap changes ignored
      if (k + 1 <= T_DONE)          rom_load_done = 1'($urandom_range(0, 1)); // R5: early done ignored
      else if (k + 1 < T_DONE + d)  rom_load_done = 1'b0;
      else if (k + 1 == T_DONE + d) rom_load_done = 1'b1;
      else                          rom_load_done = 1'($urandom_range(0, 1));
      if (abort_at != 0 && k == abort_at) begin
        sys_rst_n = 1'b0;
        tick();
        check_idle("R7");
        break;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #1;
    hold_reset(3);                   // R1 reset state
    run_seq(1'b0, 1, 0);             // R3 no ROM
    run_seq(1'b1, 1, 0);             // R5 done right at start pulse
    run_seq(1'b1, 6, 0);             // R5 delayed loader
    run_seq(1'b0, 1, T_START + 1);   // R7 abort during test
    run_seq(1'b1, 3, T_DONE + 1);    // R7 abort while waiting for loader
    run_seq(1'b0, 1, T_REL + 1);     // R7 abort after release (R8)
    run_seq(1'b1, 2, 0);             // R7 restart runs cleanly
    for (int n = 0; n < 30; n++) begin
      bit s;
      int d;
      int ab;
      s  = 1'($urandom_range(0, 1));
      d  = $urandom_range(1, 8);
      ab = ($urandom_range(0, 3) == 0) ? $urandom_range(1, T_DONE + d) : 0;
      run_seq(s, d, ab);
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule